// File: doc/BRIEF.md
# Erased Sector Zero-Bit Judge

This block decides whether a codeword that the error decoder rejected is in fact an erased sector. Erased flash reads back as all-ones. A blank sector whose stored check bytes are also all-ones therefore fails decoding, even though nothing is wrong with it. The block takes the sector as a byte stream: the data bytes come first, followed directly by the check bytes. It counts the bits that read as 0, keeping one count for the data part and one for the check part. It stops counting once the combined total goes past the correction limit.

When the stream ends, the block issues one of three verdicts:
- **Clean blank**: no zero bits in the data.
- **Blank with a few flipped bits**: the caller must overwrite the data with 0xFF bytes, and the data count is the number of corrected bits.
- **Uncorrectable**.

The block does not touch the buffer. It reports only the verdict and the two counts.

Control is a four-state machine:
- **IDLE**: the state after reset. Input is not accepted.
- **COLLECT**: bytes are accepted and counted.
- **DECIDE**: a single cycle in which the verdict is registered.
- **HOLD**: the result stays on the outputs.

Transitions:
- *start*: from any state to COLLECT. Both counts and the byte position are cleared.
- *last accepted*: COLLECT to DECIDE.
- *decided*: DECIDE to HOLD, with the done pulse.
- *idle/hold wait*: IDLE and HOLD stay where they are until the next start.

A byte presented in the same cycle as start is dropped.

Top module: `erased_sector_judge`

## Requirements
- R1: After reset, done_o is 0, verdict_o is 0 (none), both counts are 0 and in_ready_o is 0.
- R2: A start pulse clears both counts and raises in_ready_o in the next cycle.
- R3: Zero bits of the first DATA_BYTES accepted bytes (512 by default) add to data_zeros_o. Zero bits of every later byte add to ecc_zeros_o. The check part is 13 bytes by default.
- R4: Once data_zeros_o + ecc_zeros_o exceeds LIMIT (8), neither count changes again until the next start. Each count saturates at LIMIT+1 (9).
- R5: During collection in_ready_o stays 1 until the byte marked last is accepted. This includes bytes that arrive after counting has stopped, so the stream never stalls.
- R6: If the sum is at most LIMIT and the data count is 0, verdict_o is 1 (clean blank).
- R7: If the sum is at most LIMIT and the data count is nonzero, verdict_o is 2 (force to all-ones), and data_zeros_o gives the number of corrected bits.
- R8: If the sum exceeds LIMIT, verdict_o is 3 (uncorrectable).
- R9: done_o is a one-cycle pulse. It rises two clock edges after the edge that accepts the last byte. The verdict and counts then hold, with in_ready_o at 0, until the next start.
- R10: A start during collection abandons the partial sector. That sector produces no result, and counting restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new sector; clears counts |
| in_valid_i | input | 1 | Byte present |
| in_data_i | input | 8 | Byte value |
| in_last_i | input | 1 | Marks the final byte of the sector |
| in_ready_o | output | 1 | Byte accepted when high with in_valid_i |
| done_o | output | 1 | One-cycle result pulse |
| verdict_o | output | 2 | 0 none, 1 clean, 2 force all-ones, 3 uncorrectable |
| data_zeros_o | output | CW | Saturating zero count of the data part |
| ecc_zeros_o | output | CW | Saturating zero count of the check part |

## Verification
Sectors are streamed that are entirely 0xFF, that have zeros only in the check part, or that have zeros split across both parts. The combined total is placed just under, at and just over the limit, so that the clean, force and uncorrectable verdicts separate exactly at the boundary. Some sectors carry an all-zero run, or a byte that pushes the count past the limit, followed by further zeros. These show that counting stops and saturates, and that the stream keeps flowing. Valid gaps, and a restart in the middle of a sector, show that results depend only on the byte position and on the most recent start.

// File: rtl/esj_pkg.sv
package esj_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_DECIDE  = 2'd2,
        ST_HOLD    = 2'd3
    } esj_state_e;

    typedef enum logic [1:0] {
        VERDICT_NONE   = 2'd0,
        VERDICT_CLEAN  = 2'd1,
        VERDICT_FORCE  = 2'd2,
        VERDICT_UNCORR = 2'd3
    } esj_verdict_e;
endpackage

// File: rtl/esj_zero_count.sv
module esj_zero_count #(
    parameter int BYTE_W = 8,
    localparam int ZW = $clog2(BYTE_W + 1)
) (
    input  logic [BYTE_W-1:0] byte_i,
    output logic [ZW-1:0]     zeros_o
);
    always_comb begin
        zeros_o = '0;
        for (int b = 0; b < BYTE_W; b++) begin
            zeros_o = zeros_o + ZW'(~byte_i[b]);
        end
    end
endmodule

// File: rtl/esj_tally.sv
module esj_tally #(
    parameter int CW  = 4,
    parameter int ZW  = 4,
    parameter int CAP = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          add_en_i,
    input  logic [ZW-1:0] add_i,
    output logic [CW-1:0] cnt_o
);
    localparam int SW = CW + ZW;

    logic [SW-1:0] sum;
    assign sum = SW'(cnt_o) + SW'(add_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (clr_i) begin
            cnt_o <= '0;
        end else if (add_en_i) begin
            cnt_o <= (sum > SW'(CAP)) ? CW'(CAP) : sum[CW-1:0];
        end
    end
endmodule

// File: rtl/esj_ctrl.sv
module esj_ctrl
    import esj_pkg::*;
#(
    parameter int CW    = 4,
    parameter int LIMIT = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          accept_last_i,
    input  logic [CW-1:0] data_cnt_i,
    input  logic [CW-1:0] ecc_cnt_i,
    output logic          ready_o,
    output logic          done_o,
    output esj_verdict_e  verdict_o
);
    esj_state_e   state_q, state_d;
    logic [CW:0]  total;
    esj_verdict_e judged;

    assign total   = {1'b0, data_cnt_i} + {1'b0, ecc_cnt_i};
    assign ready_o = (state_q == ST_COLLECT);

    always_comb begin
        if (total > (CW+1)'(LIMIT)) begin
            judged = VERDICT_UNCORR;
        end else if (data_cnt_i != '0) begin
            judged = VERDICT_FORCE;
        end else begin
            judged = VERDICT_CLEAN;
        end
    end

    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = ST_COLLECT;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_IDLE;
                ST_COLLECT: if (accept_last_i) state_d = ST_DECIDE;
                ST_DECIDE:  state_d = ST_HOLD;
                ST_HOLD:    state_d = ST_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o    <= 1'b0;
            verdict_o <= VERDICT_NONE;
        end else if (start_i) begin
            done_o    <= 1'b0;
            verdict_o <= VERDICT_NONE;
        end else if (state_q == ST_DECIDE) begin
            done_o    <= 1'b1;
            verdict_o <= judged;
        end else begin
            done_o    <= 1'b0;
        end
    end
endmodule

// File: rtl/erased_sector_judge.sv
module erased_sector_judge
    import esj_pkg::*;
#(
    parameter int DATA_BYTES = 512,
    parameter int ECC_BYTES  = 13,
    parameter int LIMIT      = 8,
    localparam int CW        = $clog2(LIMIT + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          in_valid_i,
    input  logic [7:0]    in_data_i,
    input  logic          in_last_i,
    output logic          in_ready_o,
    output logic          done_o,
    output logic [1:0]    verdict_o,
    output logic [CW-1:0] data_zeros_o,
    output logic [CW-1:0] ecc_zeros_o
);
    localparam int TOTAL = DATA_BYTES + ECC_BYTES;
    localparam int PW    = $clog2(TOTAL + 1);
    localparam int ZW    = $clog2(9);

    logic          accept;
    logic [PW-1:0] pos_q;
    logic          in_data_part;
    logic          halted;
    logic [ZW-1:0] zeros;
    logic [CW-1:0] cnt [2];
    logic [CW:0]   total;
    esj_verdict_e  verdict;

    assign accept       = in_valid_i && in_ready_o && !start_i;
    assign in_data_part = (pos_q < PW'(DATA_BYTES));
    assign total        = {1'b0, cnt[0]} + {1'b0, cnt[1]};
    assign halted       = (total > (CW+1)'(LIMIT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (start_i) begin
            pos_q <= '0;
        end else if (accept && pos_q != PW'(TOTAL)) begin
            pos_q <= pos_q + 1'b1;
        end
    end

    esj_zero_count #(.BYTE_W(8)) u_zc (
        .byte_i  (in_data_i),
        .zeros_o (zeros)
    );

    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic lane_sel;
        assign lane_sel = (g == 0) ? in_data_part : !in_data_part;
        esj_tally #(.CW(CW), .ZW(ZW), .CAP(LIMIT + 1)) u_tally (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr_i    (start_i),
            .add_en_i (accept && !halted && lane_sel),
            .add_i    (zeros),
            .cnt_o    (cnt[g])
        );
    end

    esj_ctrl #(.CW(CW), .LIMIT(LIMIT)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .accept_last_i (accept && in_last_i),
        .data_cnt_i    (cnt[0]),
        .ecc_cnt_i     (cnt[1]),
        .ready_o       (in_ready_o),
        .done_o        (done_o),
        .verdict_o     (verdict)
    );

    assign verdict_o    = verdict;
    assign data_zeros_o = cnt[0];
    assign ecc_zeros_o  = cnt[1];
endmodule

// File: rtl/esj_checker.sv
module esj_checker #(
    parameter int CW    = 4,
    parameter int LIMIT = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          in_valid_i,
    input logic          in_last_i,
    input logic          in_ready_o,
    input logic          done_o,
    input logic [1:0]    verdict_o,
    input logic [CW-1:0] data_zeros_o,
    input logic [CW-1:0] ecc_zeros_o
);
    logic [CW:0] tot;
    assign tot = {1'b0, data_zeros_o} + {1'b0, ecc_zeros_o};

    p_start_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (data_zeros_o == '0 && ecc_zeros_o == '0 && in_ready_o));

    p_no_count_after_halt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && tot > (CW+1)'(LIMIT)) |=> ($stable(data_zeros_o) && $stable(ecc_zeros_o)));

    p_ready_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready_o && !start_i && !(in_valid_i && in_last_i)) |=> in_ready_o);

    p_clean_or_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && tot <= (CW+1)'(LIMIT)) |-> (verdict_o == ((data_zeros_o != '0) ? 2'd2 : 2'd1)));

    p_uncorr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((verdict_o == 2'd3) == (tot > (CW+1)'(LIMIT))));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> ($stable(verdict_o) && !in_ready_o));
endmodule

bind erased_sector_judge esj_checker #(.CW(CW), .LIMIT(LIMIT)) u_esj_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .in_valid_i   (in_valid_i),
    .in_last_i    (in_last_i),
    .in_ready_o   (in_ready_o),
    .done_o       (done_o),
    .verdict_o    (verdict_o),
    .data_zeros_o (data_zeros_o),
    .ecc_zeros_o  (ecc_zeros_o)
);

// File: tb/erased_sector_judge_bench.sv
module erased_sector_judge_bench;
    localparam int NB  = 525;
    localparam int NDB = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       in_valid_i = 1'b0;
    logic [7:0] in_data_i = 8'hFF;
    logic       in_last_i = 1'b0;
    logic       in_ready_o, done_o;
    logic [1:0] verdict_o;
    logic [3:0] data_zeros_o, ecc_zeros_o;

    always #10 clk = ~clk;

    erased_sector_judge u_erased_sector_judge (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .in_valid_i(in_valid_i),
        .in_data_i(in_data_i), .in_last_i(in_last_i), .in_ready_o(in_ready_o),
        .done_o(done_o), .verdict_o(verdict_o), .data_zeros_o(data_zeros_o),
        .ecc_zeros_o(ecc_zeros_o)
    );

    typedef struct packed { logic [1:0] v; logic [3:0] d; logic [3:0] e; } exp_t;
    exp_t exp_q[$];
    exp_t last_exp;
    int   n_cmp = 0, n_bad = 0, n_got = 0;
    logic [7:0] img [NB];
    bit   finished = 0;

    function automatic int zc(input logic [7:0] b);
        int z = 0;
        for (int k = 0; k < 8; k++) if (!b[k]) z++;
        return z;
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic fill_ff();
        for (int i = 0; i < NB; i++) img[i] = 8'hFF;
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            n_got++;
            if (exp_q.size() == 0) begin
                check(0, "R10", "unexpected result", 1, 0);
            end else begin
                exp_t x;
                x = exp_q.pop_front();
                check(verdict_o == x.v, (x.v == 2'd1) ? "R6" : (x.v == 2'd2) ? "R7" : "R8",
                      "verdict", verdict_o, x.v);
                check(data_zeros_o == x.d, "R3", "data count", data_zeros_o, x.d);
                check(ecc_zeros_o == x.e, "R4", "ecc count", ecc_zeros_o, x.e);
            end
        end
    end

    task automatic do_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        check(data_zeros_o == 0 && ecc_zeros_o == 0, "R2", "counts after start", data_zeros_o + ecc_zeros_o, 0);
        check(in_ready_o == 1'b1, "R2", "ready after start", in_ready_o, 1);
    endtask

    task automatic run_sector(input int gap);
        int d = 0, e = 0, got0;
        bit ready_bad = 0;
        exp_t x;
        for (int i = 0; i < NB; i++) begin
            if (d + e <= 8) begin
                if (i < NDB) d = (d + zc(img[i]) > 9) ? 9 : d + zc(img[i]);
                else         e = (e + zc(img[i]) > 9) ? 9 : e + zc(img[i]);
            end
        end
        x.v = (d + e > 8) ? 2'd3 : (d != 0) ? 2'd2 : 2'd1;
        x.d = 4'(d);
        x.e = 4'(e);
        exp_q.push_back(x);
        last_exp = x;
        got0 = n_got;
        do_start();
        for (int i = 0; i < NB; i++) begin
            if (gap != 0 && (i % gap) == 0) begin
                in_valid_i = 1'b0;
                @(negedge clk);
            end
            in_valid_i = 1'b1;
            in_data_i  = img[i];
            in_last_i  = (i == NB - 1);
            if (!in_ready_o) ready_bad = 1;
            @(negedge clk);
        end
        in_valid_i = 1'b0;
        in_last_i  = 1'b0;
        check(!ready_bad, "R5", "ready held during stream", ready_bad, 0);
        // edge A accepts last, edge B raises done: seen at second negedge
        check(done_o == 1'b0, "R9", "done one cycle after last", done_o, 0);
        @(negedge clk);
        check(done_o == 1'b1, "R9", "done two edges after last", done_o, 1);
        for (int k = 0; k < 3; k++) @(negedge clk);
        check(n_got == got0 + 1, "R9", "one result per sector", n_got - got0, 1);
        check(done_o == 1'b0 && in_ready_o == 1'b0 && verdict_o == last_exp.v &&
              data_zeros_o == last_exp.d, "R9", "result held", verdict_o, last_exp.v);
    endtask

    initial begin
        for (int c = 0; c < 150000 && !finished; c++) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(done_o == 0 && verdict_o == 0 && data_zeros_o == 0 && ecc_zeros_o == 0 && in_ready_o == 0,
              "R1", "reset state", {done_o, verdict_o, in_ready_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        fill_ff();                              // R6 all ones
        run_sector(0);

        fill_ff(); img[3] = 8'hFB; img[300] = 8'h7D; img[515] = 8'hEE;  // R7 3 data, 2 ecc
        run_sector(7);

        fill_ff(); img[512] = 8'h0F; img[524] = 8'hFE;  // R6 zeros only in check part
        run_sector(0);

        fill_ff(); img[10] = 8'hF0; img[520] = 8'h0F;   // R7 sum exactly at limit
        run_sector(5);

        fill_ff(); img[0] = 8'h00; img[1] = 8'hFE; img[2] = 8'h00; img[513] = 8'h00;  // R4 R8 halt at 9
        run_sector(0);

        for (int i = 0; i < NB; i++) img[i] = 8'h00;    // R4 saturate after overshoot
        run_sector(3);

        fill_ff(); img[100] = 8'h00; img[512] = 8'hBF;  // R8 sum one over limit
        run_sector(0);

        fill_ff(); img[20] = 8'h01; img[21] = 8'h00; img[518] = 8'h00;  // R4 7 then +8 clamps
        run_sector(0);

        // R10 restart mid-sector: partial zeros then a fresh clean sector
        do_start();
        for (int i = 0; i < 100; i++) begin
            in_valid_i = 1'b1; in_data_i = 8'h00; in_last_i = 1'b0;
            @(negedge clk);
        end
        in_valid_i = 1'b0;
        check(data_zeros_o == 9, "R10", "partial count before restart", data_zeros_o, 9);
        fill_ff();
        run_sector(11);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule